// File: doc/BRIEF.md
# Masked Pending-Interrupt Collector

This block gathers up to eight interrupt request lines into one pending register and drives a single level interrupt line toward a host. Hardware sources set pending bits with a post vector and can withdraw them with a clear vector. Software uses a small register port to read the raw pending bits, program which lines may reach the host, and acknowledge one pending line at a time by writing its index.

The mask register has inverted polarity: a 1 written to the mask address disables that line, and reading the mask address returns the value last written. Internally the block keeps an enable vector, the bitwise inverse of that value. The host line is high exactly while some pending bit is also enabled. It falls in the cycle after the mask write, acknowledge or hardware clear that removes the last such bit. Software reads are combinational on the address; writes take effect at the next clock edge.

Top module: `irq_collector`

## Requirements
- R1: After synchronous reset, the pending register is 0, the enable vector is 0 (a mask read returns 0xFF), and `irq_out` is low.
- R2: A write to the mask address (`reg_addr`=1) stores the bitwise inverse of `wr_data` as the enable vector, so a 1 disables that line. A later mask read returns exactly the byte written.
- R3: A read of the status address (`reg_addr`=0) returns the raw pending register, including bits that are disabled.
- R4: A write to the acknowledge address (`reg_addr`=2) clears the pending bit whose index is `wr_data[3:0]`. Other pending bits are unchanged, and `wr_data[7:4]` is ignored.
- R5: An acknowledge index from 8 to 15 clears no pending bit.
- R6: At each clock edge, pending bits with `hw_post` set become 1. Pending bits with `hw_clear` set become 0 unless posted in the same cycle.
- R7: When a post and an acknowledge (or a hardware clear) hit the same bit in the same cycle, the bit ends up set.
- R8: `irq_out` is a registered level equal to the OR of (pending AND enable). It is updated at the same clock edge that updates those registers.
- R9: Reads of the acknowledge address and of address 3 return 0. Writes to address 3 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 mask, 2 acknowledge, 3 unused |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `reg_addr` |
| hw_post | input | 8 | Hardware set vector for pending bits |
| hw_clear | input | 8 | Hardware clear vector for pending bits |
| irq_out | output | 1 | Level interrupt toward the host |

## Verification
The bench goes after the inverted mask polarity. A design that stored the byte without inverting it would read back the complement and raise `irq_out` for lines software meant to block. It acknowledges with indices 8 to 15 and with junk in the upper nibble. A decoder that wrapped or used more bits would wipe an unrelated pending bit. It drives a post and an acknowledge at the same bit in the same cycle, where a wrong priority loses a fresh request. It also checks that the host line falls right after the masking write or acknowledge that removes the last enabled bit; a design tracking only rising events would leave the line stuck high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    // Register-side write intent decoded from one bus write.
    typedef struct packed {
        logic mask_we;
        logic ack_we;
    } wr_intent_t;

    // True when an acknowledge index addresses an existing line.
    function automatic logic idx_in_range(input int unsigned idx, input int unsigned lines);
        return idx < lines;
    endfunction

endpackage

// File: rtl/irqc_regport.sv
module irqc_regport
    import irqc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int IDX_W = 4
) (
    input  logic             wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [LINES-1:0] wr_data,
    input  logic [LINES-1:0] pend_q,
    input  logic [LINES-1:0] enable_q,
    output logic             mask_we,
    output logic [LINES-1:0] mask_enable,
    output logic [LINES-1:0] ack_vec,
    output logic [LINES-1:0] rd_data
);

    localparam int IDX_SPAN = 1 << IDX_W;

    wr_intent_t      intent;
    reg_sel_e        sel;
    logic [IDX_W-1:0] ack_idx;

    assign sel     = reg_sel_e'(reg_addr);
    assign ack_idx = wr_data[IDX_W-1:0];

    always_comb begin
        intent = '0;
        if (wr_en) begin
            unique case (sel)
                SEL_MASK: intent.mask_we = 1'b1;
                SEL_ACK:  intent.ack_we  = 1'b1;
                default:  intent = '0;
            endcase
        end
    end

    assign mask_we     = intent.mask_we;
    assign mask_enable = ~wr_data;

    // One comparator per line; indices past the last line match nothing.
    for (genvar g = 0; g < LINES; g++) begin : g_ack
        if (idx_in_range(g, IDX_SPAN)) begin : g_hit
            assign ack_vec[g] = intent.ack_we && (ack_idx == IDX_W'(g));
        end else begin : g_miss
            assign ack_vec[g] = 1'b0;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_STATUS: rd_data = pend_q;
            SEL_MASK:   rd_data = ~enable_q;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] hw_post,
    input  logic [LINES-1:0] hw_clear,
    input  logic [LINES-1:0] ack_vec,
    output logic [LINES-1:0] pend_d,
    output logic [LINES-1:0] pend_q
);

    // Post is applied last so it wins over any same-cycle clear.
    assign pend_d = (pend_q & ~(hw_clear | ack_vec)) | hw_post;

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mask_we,
    input  logic [LINES-1:0] mask_enable,
    input  logic [LINES-1:0] pend_d,
    output logic [LINES-1:0] enable_q,
    output logic             asserting_q
);

    logic [LINES-1:0] enable_d;
    logic             want;

    assign enable_d = mask_we ? mask_enable : enable_q;
    assign want     = |(pend_d & enable_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q    <= '0;
            asserting_q <= 1'b0;
        end else begin
            enable_q <= enable_d;
            if (want != asserting_q) asserting_q <= want;
        end
    end

endmodule

// File: rtl/irq_collector.sv
module irq_collector #(
    parameter int LINES = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       reg_addr,
    input  logic [LINES-1:0] wr_data,
    output logic [LINES-1:0] rd_data,
    input  logic [LINES-1:0] hw_post,
    input  logic [LINES-1:0] hw_clear,
    output logic             irq_out
);

    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] pend_d;
    logic [LINES-1:0] enable_q;
    logic [LINES-1:0] mask_enable;
    logic [LINES-1:0] ack_vec;
    logic             mask_we;

    irqc_regport #(.LINES(LINES), .IDX_W(IDX_W)) u_port (
        .wr_en       (wr_en),
        .reg_addr    (reg_addr),
        .wr_data     (wr_data),
        .pend_q      (pend_q),
        .enable_q    (enable_q),
        .mask_we     (mask_we),
        .mask_enable (mask_enable),
        .ack_vec     (ack_vec),
        .rd_data     (rd_data)
    );

    irqc_pending #(.LINES(LINES)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .hw_post  (hw_post),
        .hw_clear (hw_clear),
        .ack_vec  (ack_vec),
        .pend_d   (pend_d),
        .pend_q   (pend_q)
    );

    irqc_gate #(.LINES(LINES)) u_gate (
        .clk         (clk),
        .rst         (rst),
        .mask_we     (mask_we),
        .mask_enable (mask_enable),
        .pend_d      (pend_d),
        .enable_q    (enable_q),
        .asserting_q (irq_out)
    );

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int LINES = 8,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       reg_addr,
    input logic [LINES-1:0] wr_data,
    input logic [LINES-1:0] hw_post,
    input logic [LINES-1:0] hw_clear,
    input logic [LINES-1:0] pend_q,
    input logic [LINES-1:0] enable_q,
    input logic             irq_out
);

    logic ack_wr;
    logic ack_oob;
    assign ack_wr  = wr_en && (reg_addr == 2'd2);
    assign ack_oob = ack_wr && (int'(wr_data[IDX_W-1:0]) >= LINES);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (pend_q == '0) && (enable_q == '0) && !irq_out);

    p_mask_inverse_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == 2'd1) |=> (enable_q == ~$past(wr_data)));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !ack_oob && hw_post == '0)
        |=> !pend_q[$past(wr_data[IDX_W-1:0])]);

    p_oob_ack_noop_r5: assert property (@(posedge clk) disable iff (rst)
        (ack_oob && hw_post == '0 && hw_clear == '0) |=> $stable(pend_q));

    p_post_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (hw_post != '0) |=> ((pend_q & $past(hw_post)) == $past(hw_post)));

    p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
        irq_out == |(pend_q & enable_q));

endmodule

bind irq_collector irqc_chk #(.LINES(LINES), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .hw_post  (hw_post),
    .hw_clear (hw_clear),
    .pend_q   (pend_q),
    .enable_q (enable_q),
    .irq_out  (irq_out)
);

// File: tb/irq_collector_tb.sv
module irq_collector_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [7:0] hw_post = 8'h00;
    logic [7:0] hw_clear = 8'h00;
    logic       irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_pend = 8'h00;
    logic [7:0] m_en   = 8'h00;

    always #10 clk = ~clk;

    irq_collector u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .hw_post(hw_post),
        .hw_clear(hw_clear), .irq_out(irq_out)
    );

    function automatic logic [7:0] ack_of(input logic we, input logic [1:0] a, input logic [7:0] d);
        if (we && a == 2'd2 && d[3:0] < 4'd8) return 8'h01 << d[2:0];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive one cycle's inputs at negedge, update model at posedge, check after.
    task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d,
                        input logic [7:0] post, input logic [7:0] clr, input string req);
        @(negedge clk);
        wr_en = we; reg_addr = a; wr_data = d; hw_post = post; hw_clear = clr;
        @(posedge clk);
        m_pend = (m_pend & ~(clr | ack_of(we, a, d))) | post;
        if (we && a == 2'd1) m_en = ~d;
        #1;
        wr_en = 1'b0; hw_post = 8'h00; hw_clear = 8'h00;
        check({req, " R8 irq"}, {7'd0, irq_out}, {7'd0, |(m_pend & m_en)});
        reg_addr = 2'd0; #1;
        check({req, " R3 status"}, rd_data, m_pend);
        reg_addr = 2'd1; #1;
        check({req, " R2 mask"}, rd_data, ~m_en);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 irq", {7'd0, irq_out}, 8'h00);
        reg_addr = 2'd0; #1; check("R1 status", rd_data, 8'h00);
        reg_addr = 2'd1; #1; check("R1 mask", rd_data, 8'hFF);

        // R2 mask readback and polarity
        step(1'b1, 2'd1, 8'h5A, 8'h00, 8'h00, "R2 mask write");
        // R3 disabled bit still visible; bit1 disabled (0x5A has bit1 set)
        step(1'b0, 2'd0, 8'h00, 8'h02, 8'h00, "R3 post disabled");
        check("R3 irq low while masked", {7'd0, irq_out}, 8'h00);
        // R6 post enabled bit raises irq
        step(1'b0, 2'd0, 8'h00, 8'h09, 8'h00, "R6 post enabled");
        check("R8 irq high", {7'd0, irq_out}, 8'h01);
        // R4 ack with junk upper nibble clears bit 3 only (0xF3 -> idx 3)
        step(1'b1, 2'd2, 8'hF3, 8'h00, 8'h00, "R4 ack idx3");
        reg_addr = 2'd0; #1; check("R4 bit3 cleared", rd_data, 8'h03);
        // R5 index 11 clears nothing
        step(1'b1, 2'd2, 8'h0B, 8'h00, 8'h00, "R5 ack idx11");
        reg_addr = 2'd0; #1; check("R5 unchanged", rd_data, 8'h03);
        // R7 post and ack on bit 0 together
        step(1'b1, 2'd2, 8'h00, 8'h01, 8'h00, "R7 post vs ack");
        reg_addr = 2'd0; #1; check("R7 post wins", rd_data, 8'h03);
        step(1'b0, 2'd0, 8'h00, 8'h20, 8'h20, "R7 post vs clear");
        reg_addr = 2'd0; #1; check("R7 post wins clear", rd_data, 8'h23);
        // R8 masking all drops irq next cycle
        step(1'b1, 2'd1, 8'hFF, 8'h00, 8'h00, "R8 mask all");
        check("R8 irq dropped", {7'd0, irq_out}, 8'h00);
        // R9 ack/spare reads return 0; spare write no effect
        step(1'b1, 2'd3, 8'h00, 8'h00, 8'h00, "R9 spare write");
        reg_addr = 2'd2; #1; check("R9 ack read", rd_data, 8'h00);
        reg_addr = 2'd3; #1; check("R9 spare read", rd_data, 8'h00);
        // R6 hardware clear
        step(1'b1, 2'd1, 8'h00, 8'h00, 8'h21, "R6 hw clear");
        reg_addr = 2'd0; #1; check("R6 clear applied", rd_data, 8'h02);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] a;
            logic       we;
            logic [7:0] d, p, c;
            a  = 2'($urandom_range(0, 3));
            we = ($urandom_range(0, 1) == 1);
            d  = 8'($urandom);
            p  = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
            c  = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
            step(we, a, d, p, c, "R6 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule